// File: doc/BRIEF.md
# Hot Swap Slot Connection Sequencer

This block manages the hardware side of connecting one backplane slot to a board that has been inserted while the system is running. Once a board is known to be present and software asks for a connection, the sequencer enables the slot's backend power and keeps the board in reset. It releases reset only after the board's own active-low health signal has been seen asserted and stable. If the board later reports that it is unhealthy, the sequencer isolates it at once and raises a sticky fault flag. If the health signal never arrives within a programmable number of cycles, the result is the same.

The slot reset is radial. It is low whenever the system host's reset is low or the sequencer's own per-slot reset is active. If the presence input drops in any state, the slot is powered down immediately and a sticky removal flag is set. Both sticky flags drive one interrupt output, and software clears them with write-one-to-clear pulses. While the fault flag is set, connection requests are refused.

The health input is synchronized, then debounced by a stability count. It is meant to have a weak pull-up on the board connector, so an undriven line reads as "not healthy". Internally the filter comes out of reset in the not-healthy state, and it is held there while the slot is unpowered.

Top module: `hs_slot_sequencer`

## Requirements
- R1: After reset, pwr_en_n_o=1, slot_rst_n_o=0, fault_o=0, removed_o=0, irq_o=0 and state_o=0. The state_o encoding is: 0 empty/unpowered, 1 powering, 2 waiting for health, 3 connected, 4 draining, 5 fault.
- R2: In state 0, with present_i=1 and fault_o=0, a conn_req_i pulse moves the slot to state 1 in the next cycle, with pwr_en_n_o=0 and slot_rst_n_o=0. A request made with present_i=0 is ignored.
- R3: The slot reaches state 3 only from state 2, after the filtered health signal is asserted. slot_rst_n_o stays 0 until then. The slot enters state 3 exactly SYNC_STAGES+STABLE_CYC+1 cycles after the cycle in which brd_ok_n_i is first driven low.
- R4: In state 3, a health loss that has passed the filter moves the slot to state 5 with fault_o=1, irq_o=1, pwr_en_n_o=1 and slot_rst_n_o=0. This happens SYNC_STAGES+STABLE_CYC+1 cycles after brd_ok_n_i goes high.
- R5: slot_rst_n_o is 0 in any cycle where host_rst_n_i=0. This takes effect combinationally and does not change the state.
- R6: A change on brd_ok_n_i that lasts fewer than STABLE_CYC cycles has no effect on the state. The filter reads "not healthy" after reset and while the slot is in state 0 or 5.
- R7: A disc_req_i pulse in state 3 gives state 4 in the next cycle, with slot_rst_n_o=0 and pwr_en_n_o still 0. In the cycle after that the slot is in state 0 with pwr_en_n_o=1.
- R8: With no health seen, the slot stays in state 2 for exactly hto_limit_i+1 cycles, then enters state 5 with fault_o=1.
- R9: fault_o and removed_o are sticky. irq_o is their OR. Pulses on w1c_fault_i and w1c_removed_i clear the matching flag in the next cycle. A set in the same cycle wins over the clear.
- R10: A conn_req_i pulse while fault_o=1 is ignored: pwr_en_n_o stays 1.
- R11: A fall of present_i in any state gives state 0 in the next cycle, with pwr_en_n_o=1, slot_rst_n_o=0 and removed_o=1.
- R12: In state 5 with present_i=1, the slot goes back to state 0 in the cycle after fault_o has cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| present_i | input | 1 | Debounced board presence, high when a board is seated |
| conn_req_i | input | 1 | Software connect request, one-cycle pulse |
| disc_req_i | input | 1 | Software disconnect request, one-cycle pulse |
| brd_ok_n_i | input | 1 | Board health status, active low, pulled up when undriven |
| host_rst_n_i | input | 1 | System host reset, active low |
| hto_limit_i | input | TO_W | Health wait limit in cycles |
| w1c_fault_i | input | 1 | Write-one-to-clear pulse for the fault flag |
| w1c_removed_i | input | 1 | Write-one-to-clear pulse for the removal flag |
| pwr_en_n_o | output | 1 | Backend power enable, active low |
| slot_rst_n_o | output | 1 | Radial slot reset, active low |
| state_o | output | 3 | Current connection state |
| fault_o | output | 1 | Sticky fault flag |
| removed_o | output | 1 | Sticky removal flag |
| irq_o | output | 1 | Interrupt, high while any flag is set |

## Verification
Results from requests, presence and flag clears appear in the first cycle after the edge that samples them. A host reset acts on slot_rst_n_o in the same cycle. Anything that depends on health appears SYNC_STAGES+STABLE_CYC+1 cycles after the health input changes, and a timeout shows as hto_limit_i+1 cycles spent waiting. The bench drives inputs and samples outputs only on the falling clock edge, inside one stepping task. Each check counts those steps from the drive to the expected change, and checks the cycle just before the boundary as well as the boundary itself. The behavioural board model asserts health after a random delay, and every entry into the connected state is checked against the exact latency from that assertion.

// File: rtl/hs_slot_pkg.sv
package hs_slot_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      SLOT_EMPTY       = 3'd0,
      SLOT_POWERING    = 3'd1,
      SLOT_WAIT_HEALTH = 3'd2,
      SLOT_CONNECTED   = 3'd3,
      SLOT_DRAIN       = 3'd4,
      SLOT_FAULT       = 3'd5
   } slot_state_e;

   localparam int N_STATUS     = 2;
   localparam int STAT_FAULT   = 0;
   localparam int STAT_REMOVED = 1;

endpackage

// File: rtl/hs_sync_filter.sv
module hs_sync_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   STABLE_CYC  = 4,
   parameter logic RESET_VAL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclr_i,
   input  logic din_i,
   output logic dout_o
);

   localparam int CNT_W = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   synced;
   logic                   filt_q;

   initial begin : elab_chk
      if (SYNC_STAGES < 2) $error("hs_sync_filter: SYNC_STAGES must be at least 2");
      if (STABLE_CYC < 1)  $error("hs_sync_filter: STABLE_CYC must be at least 1");
   end

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      chain_q[0] <= RESET_VAL;
               else if (sclr_i) chain_q[0] <= RESET_VAL;
               else             chain_q[0] <= din_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      chain_q[g] <= RESET_VAL;
               else if (sclr_i) chain_q[g] <= RESET_VAL;
               else             chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign synced = chain_q[SYNC_STAGES-1];

   generate
      if (STABLE_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      filt_q <= RESET_VAL;
            else if (sclr_i) filt_q <= RESET_VAL;
            else             filt_q <= synced;
         end
      end else begin : g_count
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYC - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_q <= RESET_VAL;
               cnt_q  <= '0;
            end else if (sclr_i) begin
               filt_q <= RESET_VAL;
               cnt_q  <= '0;
            end else if (synced == filt_q) begin
               cnt_q  <= '0;
            end else if (cnt_q == CNT_LAST) begin
               filt_q <= synced;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign dout_o = filt_q;

endmodule

// File: rtl/hs_health_timer.sv
module hs_health_timer #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            run_i,
   input  logic [TO_W-1:0] limit_i,
   output logic            expired_o
);

   logic [TO_W-1:0] cnt_q;
   logic            at_zero;

   initial begin : elab_chk
      if (TO_W < 2) $error("hs_health_timer: TO_W must be at least 2");
   end

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load_i)            cnt_q <= limit_i;
      else if (run_i && !at_zero) cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = run_i && at_zero;

endmodule

// File: rtl/hs_sticky_bits.sv
module hs_sticky_bits #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);

   logic [N-1:0] bits_q;

   initial begin : elab_chk
      if (N < 1) $error("hs_sticky_bits: N must be at least 1");
   end

   genvar b;
   generate
      for (b = 0; b < N; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bits_q[b] <= 1'b0;
            else if (set_i[b]) bits_q[b] <= 1'b1;
            else if (clr_i[b]) bits_q[b] <= 1'b0;
         end
      end
   endgenerate

   assign q_o = bits_q;

endmodule

// File: rtl/hs_conn_fsm.sv
module hs_conn_fsm
   import hs_slot_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        present_i,
   input  logic        conn_req_i,
   input  logic        disc_req_i,
   input  logic        health_ok_i,
   input  logic        expired_i,
   input  logic        fault_i,
   output slot_state_e state_o,
   output logic        set_fault_o,
   output logic        set_removed_o
);

   slot_state_e state_q;
   slot_state_e nxt;
   logic        prev_present_q;

   always_comb begin
      nxt         = state_q;
      set_fault_o = 1'b0;
      if (!present_i) begin
         nxt = SLOT_EMPTY;
      end else begin
         case (state_q)
            SLOT_EMPTY: begin
               if (conn_req_i && !fault_i) nxt = SLOT_POWERING;
            end
            SLOT_POWERING: begin
               nxt = SLOT_WAIT_HEALTH;
            end
            SLOT_WAIT_HEALTH: begin
               if (health_ok_i) begin
                  nxt = SLOT_CONNECTED;
               end else if (expired_i) begin
                  nxt         = SLOT_FAULT;
                  set_fault_o = 1'b1;
               end
            end
            SLOT_CONNECTED: begin
               if (!health_ok_i) begin
                  nxt         = SLOT_FAULT;
                  set_fault_o = 1'b1;
               end else if (disc_req_i) begin
                  nxt = SLOT_DRAIN;
               end
            end
            SLOT_DRAIN: begin
               nxt = SLOT_EMPTY;
            end
            SLOT_FAULT: begin
               if (!fault_i) nxt = SLOT_EMPTY;
            end
            default: begin
               nxt = SLOT_EMPTY;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= SLOT_EMPTY;
         prev_present_q <= 1'b0;
      end else begin
         state_q        <= nxt;
         prev_present_q <= present_i;
      end
   end

   assign set_removed_o = prev_present_q && !present_i;
   assign state_o       = state_q;

endmodule

// File: rtl/hs_slot_sequencer.sv
module hs_slot_sequencer
   import hs_slot_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4,
   parameter int TO_W        = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                present_i,
   input  logic                conn_req_i,
   input  logic                disc_req_i,
   input  logic                brd_ok_n_i,
   input  logic                host_rst_n_i,
   input  logic [TO_W-1:0]     hto_limit_i,
   input  logic                w1c_fault_i,
   input  logic                w1c_removed_i,
   output logic                pwr_en_n_o,
   output logic                slot_rst_n_o,
   output logic [STATE_W-1:0]  state_o,
   output logic                fault_o,
   output logic                removed_o,
   output logic                irq_o
);

   slot_state_e         state_q;
   logic                ok_filt_n;
   logic                health_ok;
   logic                filt_clr;
   logic                tmo_expired;
   logic                set_fault;
   logic                set_removed;
   logic [N_STATUS-1:0] stat_set;
   logic [N_STATUS-1:0] stat_clr;
   logic [N_STATUS-1:0] stat_q;
   logic                powered;
   logic                local_rst_n;

   initial begin : elab_chk
      if (SYNC_STAGES < 2) $error("hs_slot_sequencer: SYNC_STAGES must be at least 2");
      if (STABLE_CYC < 1)  $error("hs_slot_sequencer: STABLE_CYC must be at least 1");
      if (TO_W < 2)        $error("hs_slot_sequencer: TO_W must be at least 2");
   end

   // Health qualification is held in reset while the slot is unpowered.
   assign filt_clr = (state_q == SLOT_EMPTY) || (state_q == SLOT_FAULT);

   hs_sync_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .STABLE_CYC  (STABLE_CYC),
      .RESET_VAL   (1'b1)
   ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclr_i (filt_clr),
      .din_i  (brd_ok_n_i),
      .dout_o (ok_filt_n)
   );

   assign health_ok = !ok_filt_n;

   hs_health_timer #(
      .TO_W (TO_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (state_q == SLOT_POWERING),
      .run_i     (state_q == SLOT_WAIT_HEALTH),
      .limit_i   (hto_limit_i),
      .expired_o (tmo_expired)
   );

   hs_conn_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .present_i     (present_i),
      .conn_req_i    (conn_req_i),
      .disc_req_i    (disc_req_i),
      .health_ok_i   (health_ok),
      .expired_i     (tmo_expired),
      .fault_i       (stat_q[STAT_FAULT]),
      .state_o       (state_q),
      .set_fault_o   (set_fault),
      .set_removed_o (set_removed)
   );

   always_comb begin
      stat_set               = '0;
      stat_clr               = '0;
      stat_set[STAT_FAULT]   = set_fault;
      stat_set[STAT_REMOVED] = set_removed;
      stat_clr[STAT_FAULT]   = w1c_fault_i;
      stat_clr[STAT_REMOVED] = w1c_removed_i;
   end

   hs_sticky_bits #(
      .N (N_STATUS)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stat_set),
      .clr_i (stat_clr),
      .q_o   (stat_q)
   );

   always_comb begin
      case (state_q)
         SLOT_POWERING, SLOT_WAIT_HEALTH,
         SLOT_CONNECTED, SLOT_DRAIN: powered = 1'b1;
         default:                    powered = 1'b0;
      endcase
   end

   assign local_rst_n  = (state_q == SLOT_CONNECTED);
   assign pwr_en_n_o   = !powered;
   // Active-low resets combine by AND, which is an OR of the asserted levels.
   assign slot_rst_n_o = host_rst_n_i && local_rst_n;
   assign state_o      = state_q;
   assign fault_o      = stat_q[STAT_FAULT];
   assign removed_o    = stat_q[STAT_REMOVED];
   assign irq_o        = |stat_q;

endmodule

// File: rtl/hs_slot_sequencer_chk.sv
module hs_slot_sequencer_chk
   import hs_slot_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               present_i,
   input logic               conn_req_i,
   input logic               host_rst_n_i,
   input logic               w1c_fault_i,
   input logic               pwr_en_n_o,
   input logic               slot_rst_n_o,
   input logic               fault_o,
   input logic               removed_o,
   input logic [STATE_W-1:0] state_i,
   input logic               health_ok_i
);

   logic armed_q;
   logic st_conn;
   logic st_empty;
   logic st_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   assign st_conn  = (state_i == SLOT_CONNECTED);
   assign st_empty = (state_i == SLOT_EMPTY);
   assign st_fault = (state_i == SLOT_FAULT);

   // R3: connection is entered only after qualified health
   a_r3_release_after_health: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $rose(st_conn)) |-> $past(health_ok_i));

   // R5: host reset always reaches the slot
   a_r5_host_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rst_n_i |-> !slot_rst_n_o);

   // R2: power comes on only after a connect request
   a_r2_power_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(pwr_en_n_o)) |-> $past(conn_req_i));

   // R4: health loss while connected isolates the board
   a_r4_loss_isolates: assert property (@(posedge clk) disable iff (!rst_n)
      (st_conn && !health_ok_i && present_i) |=> (fault_o && pwr_en_n_o && !slot_rst_n_o));

   // R11: removal lands in the empty state with the flag set
   a_r11_removal: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(present_i)) |=> (st_empty && removed_o));

   // R10: a set fault flag keeps power off
   a_r10_fault_blocks_power: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && st_empty) |=> pwr_en_n_o);

   // R9: the fault flag clears only by software
   a_r9_fault_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(fault_o)) |-> $past(w1c_fault_i));

   // R12: leaving fault once the flag is gone
   a_r12_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fault && !fault_o && present_i) |=> st_empty);

endmodule

bind hs_slot_sequencer hs_slot_sequencer_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .present_i    (present_i),
   .conn_req_i   (conn_req_i),
   .host_rst_n_i (host_rst_n_i),
   .w1c_fault_i  (w1c_fault_i),
   .pwr_en_n_o   (pwr_en_n_o),
   .slot_rst_n_o (slot_rst_n_o),
   .fault_o      (fault_o),
   .removed_o    (removed_o),
   .state_i      (state_q),
   .health_ok_i  (health_ok)
);

// File: tb/hs_slot_sequencer_test.sv
module hs_slot_sequencer_test;

   localparam int SYNC = 2;
   localparam int STAB = 4;
   localparam int TOW  = 16;
   localparam int LAT  = SYNC + STAB + 1;

   localparam logic [2:0] S_EMPTY = 3'd0;
   localparam logic [2:0] S_PWR   = 3'd1;
   localparam logic [2:0] S_WAIT  = 3'd2;
   localparam logic [2:0] S_CONN  = 3'd3;
   localparam logic [2:0] S_DRAIN = 3'd4;
   localparam logic [2:0] S_FAULT = 3'd5;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           present_i;
   logic           conn_req_i;
   logic           disc_req_i;
   logic           brd_ok_n_i;
   logic           host_rst_n_i;
   logic [TOW-1:0] hto_limit_i;
   logic           w1c_fault_i;
   logic           w1c_removed_i;
   logic           pwr_en_n_o;
   logic           slot_rst_n_o;
   logic [2:0]     state_o;
   logic           fault_o;
   logic           removed_o;
   logic           irq_o;

   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   int   ok_since = 0;
   int   dly = 0;
   int   board_mode = 1;   // 0 responsive, 1 silent, 2 driven by the bench
   logic [2:0] prev_state = 3'd0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   hs_slot_sequencer #(
      .SYNC_STAGES (SYNC),
      .STABLE_CYC  (STAB),
      .TO_W        (TOW)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .present_i     (present_i),
      .conn_req_i    (conn_req_i),
      .disc_req_i    (disc_req_i),
      .brd_ok_n_i    (brd_ok_n_i),
      .host_rst_n_i  (host_rst_n_i),
      .hto_limit_i   (hto_limit_i),
      .w1c_fault_i   (w1c_fault_i),
      .w1c_removed_i (w1c_removed_i),
      .pwr_en_n_o    (pwr_en_n_o),
      .slot_rst_n_o  (slot_rst_n_o),
      .state_o       (state_o),
      .fault_o       (fault_o),
      .removed_o     (removed_o),
      .irq_o         (irq_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int release_latency();
      return LAT;
   endfunction

   function automatic int wait_cycles(input int limit);
      return limit + 1;
   endfunction

   // One falling-edge step: monitor, then board model update.
   task automatic tick();
      @(negedge clk);
      cyc++;
      if (rst_n && state_o == S_CONN && prev_state != S_CONN) begin
         chk("R3", "health low at connect", int'(brd_ok_n_i), 0);
         chk("R3", "connect latency", cyc - ok_since, release_latency());
      end
      prev_state = state_o;
      case (board_mode)
         0: begin
            if (pwr_en_n_o) begin
               brd_ok_n_i = 1'b1;
               dly = $urandom_range(40, 3);
            end else if (dly > 0) begin
               dly--;
            end else if (brd_ok_n_i) begin
               brd_ok_n_i = 1'b0;
               ok_since = cyc;
            end
         end
         1: brd_ok_n_i = 1'b1;
         default: ;
      endcase
   endtask

   task automatic pulse_conn();
      conn_req_i = 1'b1;
      tick();
      conn_req_i = 1'b0;
   endtask

   task automatic pulse_disc();
      disc_req_i = 1'b1;
      tick();
      disc_req_i = 1'b0;
   endtask

   task automatic wait_for(input logic [2:0] tgt, input int maxc, output bit hit);
      hit = (state_o == tgt);
      for (int i = 0; i < maxc && !hit; i++) begin
         tick();
         if (state_o == tgt) hit = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit hit;
      int wcnt;
      int lim;
      void'($urandom(32'h1d5e_ed01));
      rst_n = 1'b0; present_i = 1'b0; conn_req_i = 1'b0; disc_req_i = 1'b0;
      brd_ok_n_i = 1'b1; host_rst_n_i = 1'b1; hto_limit_i = 16'd200;
      w1c_fault_i = 1'b0; w1c_removed_i = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1", "pwr_en_n", int'(pwr_en_n_o), 1);
      chk("R1", "slot_rst_n", int'(slot_rst_n_o), 0);
      chk("R1", "state", int'(state_o), int'(S_EMPTY));
      chk("R1", "irq/fault/removed", int'({irq_o, fault_o, removed_o}), 0);

      // R2: no presence, request ignored
      pulse_conn();
      chk("R2", "no-presence state", int'(state_o), int'(S_EMPTY));
      chk("R2", "no-presence pwr", int'(pwr_en_n_o), 1);

      present_i = 1'b1;
      board_mode = 0;
      repeat (2) tick();
      pulse_conn();
      chk("R2", "powering state", int'(state_o), int'(S_PWR));
      chk("R2", "power on", int'(pwr_en_n_o), 0);
      chk("R2", "reset held", int'(slot_rst_n_o), 0);
      wait_for(S_CONN, 300, hit);
      chk("R3", "connected reached", int'(hit), 1);
      chk("R3", "reset released", int'(slot_rst_n_o), 1);

      // R5: host reset ORs into the slot reset
      host_rst_n_i = 1'b0;
      tick();
      chk("R5", "slot reset follows host", int'(slot_rst_n_o), 0);
      chk("R5", "state kept", int'(state_o), int'(S_CONN));
      host_rst_n_i = 1'b1;
      tick();
      chk("R5", "slot reset back", int'(slot_rst_n_o), 1);

      // R6: a health glitch one cycle short of the stability count
      board_mode = 2;
      brd_ok_n_i = 1'b1;
      repeat (STAB - 1) tick();
      brd_ok_n_i = 1'b0;
      repeat (LAT + 2) tick();
      chk("R6", "short glitch ignored", int'(state_o), int'(S_CONN));
      chk("R6", "no fault from glitch", int'(fault_o), 0);
      board_mode = 0;

      // R7: ordered disconnect
      pulse_disc();
      chk("R7", "drain state", int'(state_o), int'(S_DRAIN));
      chk("R7", "reset first", int'(slot_rst_n_o), 0);
      chk("R7", "power still on", int'(pwr_en_n_o), 0);
      tick();
      chk("R7", "empty state", int'(state_o), int'(S_EMPTY));
      chk("R7", "power off", int'(pwr_en_n_o), 1);

      // Random connect and disconnect rounds
      for (int r = 0; r < 6; r++) begin
         repeat ($urandom_range(20, 2)) tick();
         pulse_conn();
         wait_for(S_CONN, 300, hit);
         chk("R3", "random round connected", int'(hit), 1);
         repeat ($urandom_range(30, 1)) tick();
         pulse_disc();
         tick();
         chk("R7", "random round empty", int'(state_o), int'(S_EMPTY));
      end

      // R4: health loss while connected
      repeat (5) tick();
      pulse_conn();
      wait_for(S_CONN, 300, hit);
      chk("R4", "connected before loss", int'(hit), 1);
      board_mode = 2;
      brd_ok_n_i = 1'b1;
      repeat (LAT - 1) tick();
      chk("R4", "still connected one cycle early", int'(state_o), int'(S_CONN));
      tick();
      chk("R4", "fault state", int'(state_o), int'(S_FAULT));
      chk("R4", "fault flag and irq", int'({fault_o, irq_o}), 3);
      chk("R4", "isolated power", int'(pwr_en_n_o), 1);
      chk("R4", "isolated reset", int'(slot_rst_n_o), 0);
      board_mode = 1;

      // R10: requests refused while the fault flag is set
      pulse_conn();
      chk("R10", "request in fault", int'(state_o), int'(S_FAULT));
      present_i = 1'b0;
      tick();
      chk("R11", "removal to empty", int'(state_o), int'(S_EMPTY));
      chk("R11", "removed flag", int'(removed_o), 1);
      present_i = 1'b1;
      tick();
      pulse_conn();
      chk("R10", "request refused state", int'(state_o), int'(S_EMPTY));
      chk("R10", "request refused power", int'(pwr_en_n_o), 1);

      // R9: write-one-to-clear, one flag at a time
      w1c_fault_i = 1'b1;
      tick();
      w1c_fault_i = 1'b0;
      chk("R9", "fault cleared", int'(fault_o), 0);
      chk("R9", "removed kept", int'(removed_o), 1);
      chk("R9", "irq still set", int'(irq_o), 1);
      w1c_removed_i = 1'b1;
      tick();
      w1c_removed_i = 1'b0;
      chk("R9", "removed cleared", int'(removed_o), 0);
      chk("R9", "irq cleared", int'(irq_o), 0);

      // R8: health wait timeout with a silent board
      lim = $urandom_range(30, 5);
      hto_limit_i = TOW'(lim);
      pulse_conn();
      wcnt = 0;
      for (int i = 0; i < 200; i++) begin
         tick();
         if (state_o != S_WAIT) break;
         wcnt++;
      end
      chk("R8", "cycles in wait", wcnt, wait_cycles(lim));
      chk("R8", "timeout fault state", int'(state_o), int'(S_FAULT));
      chk("R8", "timeout fault flag", int'(fault_o), 1);

      // R12: leaving fault after the flag clears
      w1c_fault_i = 1'b1;
      tick();
      w1c_fault_i = 1'b0;
      chk("R12", "flag clear", int'(fault_o), 0);
      chk("R12", "fault held one cycle", int'(state_o), int'(S_FAULT));
      tick();
      chk("R12", "back to empty", int'(state_o), int'(S_EMPTY));

      // R11: removal while waiting for health
      hto_limit_i = 16'd200;
      pulse_conn();
      repeat (2) tick();
      chk("R11", "waiting before removal", int'(state_o), int'(S_WAIT));
      present_i = 1'b0;
      tick();
      chk("R11", "empty after removal", int'(state_o), int'(S_EMPTY));
      chk("R11", "removal flag", int'(removed_o), 1);
      chk("R11", "power off after removal", int'(pwr_en_n_o), 1);
      chk("R11", "reset after removal", int'(slot_rst_n_o), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule